// File: doc/BRIEF.md
# Low-Power Entry Debug Handshake Controller

This block sits between a device's power controller and an external debug tool. It stops the device from entering a low-power mode until the tool has agreed to it. Each supported low-power mode has its own pending flag in a 16-bit control word. The debug tool reaches that word over a simple single-address register bus.

When the power controller raises a request for a mode and wake-up debug support is on, the block sets that mode's pending flag and holds the request. The tool reads the flag, then writes a 0 to it. One cycle after the flag clears, the block gives the power controller a one-cycle grant, provided the request is still raised. If the request is withdrawn first, the flag drops and no grant is given.

With wake-up debug support off, requests are granted straight away and no flag is raised. The same enable bit drives an output that tells the debug logic to stay alive across a wake-up.

Top module: `lpdbg_sync_ctrl`

## Requirements
- R1: After a synchronous reset, every flag is 0, the wake-debug enable is 0, all grant outputs are 0 and `bus_rdata` is 0.
- R2: Bit 15 of the control word is the wake-debug enable. A bus write to the control address loads it from `bus_wdata[15]`, it reads back at bit 15, and `dbg_wake_en` follows it from the cycle after the write.
- R3: Every bit of the control word other than 15, 9 and 8 reads as 0, whatever was written to it.
- R4: When the enable is 1 and request `lp_req[i]` is seen high by an idle mode, flag i is set one clock later. Flag i sits at bit 8+i: mode 0 at bit 8, mode 1 at bit 9.
- R5: No grant is issued for a mode while its flag is 1.
- R6: A bus write with 0 in a flag's bit clears that flag. A write with 1 in that bit leaves the flag unchanged and can never set it.
- R7: Once a flag is cleared by the bus, `lp_grant[i]` is 1 for exactly one cycle, one clock after the flag cleared, if the request is still high at that point.
- R8: If the request falls while the flag is pending, the flag clears on the next clock and no grant is issued.
- R9: When the enable is 0, a request seen by an idle mode produces a one-cycle grant one clock later, and no flag is set.
- R10: A request produces at most one grant. The next grant needs the request to fall and rise again.
- R11: The modes are independent. A request, an acknowledge or a withdrawal on one mode does not change the other mode's flag or grant.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| bus_addr | input | ADDR_W | Register bus address |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data, registered, valid the cycle after `bus_rd` |
| lp_req | input | NUM_MODES | Low-power entry request, one bit per mode, held until granted or withdrawn |
| lp_grant | output | NUM_MODES | One-cycle entry grant, one bit per mode |
| dbg_wake_en | output | 1 | Wake-up debug enable |

## Verification
The embedded properties check the rules that hold on every cycle:
- a grant is never more than one cycle long;
- no grant is issued while a flag is pending;
- a flag only rises from a live request with the enable set;
- a withdrawn request clears its flag without granting;
- with the enable off, a request is granted without raising a flag.

Some behaviour can only be shown by the bench's scenarios, because it depends on the bus traffic and on what is read back:
- the exact grant cycle after an acknowledge;
- the read-as-zero bits;
- writes of 1 being ignored;
- one mode being acknowledged while the other stays pending.

// File: rtl/lpdbg_pkg.sv
package lpdbg_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_PEND = 2'd1,
    ST_ACKD = 2'd2,
    ST_HOLD = 2'd3
  } mode_st_e;
endpackage

// File: rtl/lpdbg_bus_decode.sv
module lpdbg_bus_decode #(
  parameter int ADDR_W    = 4,
  parameter int DATA_W    = 16,
  parameter int CTRL_ADDR = 0,
  parameter int NUM_MODES = 2,
  parameter int FLAG_LSB  = 8,
  parameter int WAKE_BIT  = 15
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [ADDR_W-1:0]    bus_addr,
  input  logic                 bus_wr,
  input  logic                 bus_rd,
  input  logic [DATA_W-1:0]    bus_wdata,
  output logic                 rd_hit,
  output logic [NUM_MODES-1:0] clr_mask,
  output logic                 wake_en
);
  localparam logic [ADDR_W-1:0] HIT_ADDR = ADDR_W'(CTRL_ADDR);

  logic addr_hit;
  logic wr_hit;

  assign addr_hit = (bus_addr == HIT_ADDR);
  assign wr_hit   = bus_wr && addr_hit;
  assign rd_hit   = bus_rd && addr_hit;

  // Acknowledge: a 0 in a flag's bit clears it. A 1 in that bit does nothing.
  for (genvar i = 0; i < NUM_MODES; i++) begin : g_clr
    assign clr_mask[i] = wr_hit && !bus_wdata[FLAG_LSB+i];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wake_en <= 1'b0;
    end else if (wr_hit) begin
      wake_en <= bus_wdata[WAKE_BIT];
    end
  end

  // R2: the enable takes the written bit one cycle after the write.
  p_wake_load_r2: assert property (@(posedge clk) disable iff (rst)
    (bus_wr && addr_hit) |=> (wake_en == $past(bus_wdata[WAKE_BIT])));

  // R2: without a write, the enable keeps its value.
  p_wake_hold_r2: assert property (@(posedge clk) disable iff (rst)
    !(bus_wr && addr_hit) |=> $stable(wake_en));
endmodule

// File: rtl/lpdbg_mode_fsm.sv
module lpdbg_mode_fsm
  import lpdbg_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic req,
  input  logic en,
  input  logic clr,
  output logic flag,
  output logic grant
);
  mode_st_e st;

  always_ff @(posedge clk) begin
    if (rst) begin
      st    <= ST_IDLE;
      flag  <= 1'b0;
      grant <= 1'b0;
    end else begin
      grant <= 1'b0;
      unique case (st)
        ST_IDLE: begin
          if (req) begin
            if (en) begin
              flag <= 1'b1;
              st   <= ST_PEND;
            end else begin
              grant <= 1'b1;
              st    <= ST_HOLD;
            end
          end
        end
        ST_PEND: begin
          if (!req) begin
            flag <= 1'b0;
            st   <= ST_IDLE;
          end else if (clr) begin
            flag <= 1'b0;
            st   <= ST_ACKD;
          end
        end
        ST_ACKD: begin
          if (req) begin
            grant <= 1'b1;
            st    <= ST_HOLD;
          end else begin
            st <= ST_IDLE;
          end
        end
        ST_HOLD: begin
          if (!req) st <= ST_IDLE;
        end
        default: st <= ST_IDLE;
      endcase
    end
  end

  // R7: a grant lasts exactly one cycle.
  p_grant_single_r7: assert property (@(posedge clk) disable iff (rst)
    grant |=> !grant);

  // R5: no grant while the flag is pending.
  p_no_grant_pending_r5: assert property (@(posedge clk) disable iff (rst)
    flag |-> !grant);

  // R4: a flag only rises from a request with the enable set.
  p_flag_rise_r4: assert property (@(posedge clk) disable iff (rst)
    $rose(flag) |-> $past(req && en));

  // R8: a withdrawn request clears the flag and gives no grant.
  p_withdraw_r8: assert property (@(posedge clk) disable iff (rst)
    (flag && !req) |=> (!flag && !grant));

  // R6: the flag stays set until the bus clears it or the request falls.
  p_flag_keep_r6: assert property (@(posedge clk) disable iff (rst)
    (flag && req && !clr) |=> flag);

  // R9: with the enable off, a request is granted and raises no flag.
  p_bypass_r9: assert property (@(posedge clk) disable iff (rst)
    (st == ST_IDLE && req && !en) |=> (grant && !flag));

  // R10: a grant leaves the mode waiting for the request to fall.
  p_one_grant_r10: assert property (@(posedge clk) disable iff (rst)
    (grant && req) |=> !grant);
endmodule

// File: rtl/lpdbg_readback.sv
module lpdbg_readback #(
  parameter int DATA_W    = 16,
  parameter int NUM_MODES = 2,
  parameter int FLAG_LSB  = 8,
  parameter int WAKE_BIT  = 15
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 rd_hit,
  input  logic                 wake_en,
  input  logic [NUM_MODES-1:0] flags,
  output logic [DATA_W-1:0]    rdata
);
  logic [DATA_W-1:0] word;

  always_comb begin
    word = '0;
    word[WAKE_BIT] = wake_en;
    word[FLAG_LSB +: NUM_MODES] = flags;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata <= '0;
    end else if (rd_hit) begin
      rdata <= word;
    end
  end

  // R3: a read returns the enable and the flags as they were when it was taken.
  p_read_fields_r3: assert property (@(posedge clk) disable iff (rst)
    rd_hit |=> (rdata[WAKE_BIT] == $past(wake_en)) &&
               (rdata[FLAG_LSB +: NUM_MODES] == $past(flags)));
endmodule

// File: rtl/lpdbg_sync_ctrl.sv
module lpdbg_sync_ctrl #(
  parameter int ADDR_W    = 4,
  parameter int CTRL_ADDR = 0,
  parameter int NUM_MODES = 2
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [ADDR_W-1:0]    bus_addr,
  input  logic                 bus_wr,
  input  logic                 bus_rd,
  input  logic [15:0]          bus_wdata,
  output logic [15:0]          bus_rdata,
  input  logic [NUM_MODES-1:0] lp_req,
  output logic [NUM_MODES-1:0] lp_grant,
  output logic                 dbg_wake_en
);
  localparam int DATA_W   = 16;
  localparam int FLAG_LSB = 8;
  localparam int WAKE_BIT = 15;

  logic                 rd_hit;
  logic [NUM_MODES-1:0] clr_mask;
  logic                 wake_en;
  logic [NUM_MODES-1:0] flags;

  lpdbg_bus_decode #(
    .ADDR_W   (ADDR_W),
    .DATA_W   (DATA_W),
    .CTRL_ADDR(CTRL_ADDR),
    .NUM_MODES(NUM_MODES),
    .FLAG_LSB (FLAG_LSB),
    .WAKE_BIT (WAKE_BIT)
  ) u_dec (
    .clk      (clk),
    .rst      (rst),
    .bus_addr (bus_addr),
    .bus_wr   (bus_wr),
    .bus_rd   (bus_rd),
    .bus_wdata(bus_wdata),
    .rd_hit   (rd_hit),
    .clr_mask (clr_mask),
    .wake_en  (wake_en)
  );

  for (genvar i = 0; i < NUM_MODES; i++) begin : g_mode
    lpdbg_mode_fsm u_fsm (
      .clk  (clk),
      .rst  (rst),
      .req  (lp_req[i]),
      .en   (wake_en),
      .clr  (clr_mask[i]),
      .flag (flags[i]),
      .grant(lp_grant[i])
    );
  end

  lpdbg_readback #(
    .DATA_W   (DATA_W),
    .NUM_MODES(NUM_MODES),
    .FLAG_LSB (FLAG_LSB),
    .WAKE_BIT (WAKE_BIT)
  ) u_rb (
    .clk    (clk),
    .rst    (rst),
    .rd_hit (rd_hit),
    .wake_en(wake_en),
    .flags  (flags),
    .rdata  (bus_rdata)
  );

  assign dbg_wake_en = wake_en;

  // R1: out of reset, nothing is granted.
  p_reset_quiet_r1: assert property (@(posedge clk)
    $past(rst) |-> (lp_grant == '0));
endmodule

// File: tb/sim_lpdbg_sync_ctrl.sv
`timescale 1ns/100ps
module sim_lpdbg_sync_ctrl;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [3:0]  bus_addr = '0;
  logic        bus_wr = 1'b0;
  logic        bus_rd = 1'b0;
  logic [15:0] bus_wdata = '0;
  logic [15:0] bus_rdata;
  logic [1:0]  lp_req = '0;
  logic [1:0]  lp_grant;
  logic        dbg_wake_en;

  int n_chk = 0;
  int n_bad = 0;
  int gcnt0 = 0;
  int gcnt1 = 0;
  bit done  = 1'b0;

  always #2.5 clk = ~clk;

  lpdbg_sync_ctrl u0 (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .lp_req(lp_req),
    .lp_grant(lp_grant), .dbg_wake_en(dbg_wake_en)
  );

  // Count grants as seen at the falling edge.
  always @(negedge clk) begin
    if (!rst) begin
      gcnt0 += int'(lp_grant[0]);
      gcnt1 += int'(lp_grant[1]);
    end
  end

  // Upper 16 bits: data written. Lower 16 bits: value read back. Flags are never pending here.
  localparam logic [31:0] REG_VEC [0:5] = '{
    32'hFFFF_8000, 32'h0000_0000, 32'h7FFF_0000,
    32'h8300_8000, 32'hA5A5_8000, 32'h5A5A_0000
  };

  task automatic step();
    @(negedge clk);
  endtask

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [15:0] d);
    bus_wr = 1'b1;
    bus_wdata = d;
    step();
    bus_wr = 1'b0;
  endtask

  task automatic rd(output logic [15:0] d);
    bus_rd = 1'b1;
    step();
    bus_rd = 1'b0;
    d = bus_rdata;
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      summary();
      $finish;
    end
  end

  initial begin
    logic [15:0] v;
    int g0;
    int g1;
    repeat (3) step();
    rst = 1'b0;
    step();

    // R1: reset state
    check("R1 rdata", 32'(bus_rdata), 32'h0);
    check("R1 grant", 32'(lp_grant), 32'h0);
    check("R1 wake", 32'(dbg_wake_en), 32'h0);
    rd(v);
    check("R1 read", 32'(v), 32'h0);

    // R2 R3 R6: walk the register vector table
    for (int k = 0; k < 6; k++) begin
      wr(REG_VEC[k][31:16]);
      check("R2 wake_out", 32'(dbg_wake_en), 32'(REG_VEC[k][31]));
      rd(v);
      check("R3 readback", 32'(v), 32'(REG_VEC[k][15:0]));
    end

    // R4 R5 R7 R10: handshake on mode 0
    wr(16'h8000);
    g0 = gcnt0;
    lp_req[0] = 1'b1;
    step();
    rd(v);
    check("R4 flag set", 32'(v), 32'h8100);
    repeat (4) step();
    check("R5 no grant pending", 32'(gcnt0 - g0), 32'h0);
    wr(16'h8000);
    check("R7 no grant on clear cycle", 32'(lp_grant[0]), 32'h0);
    step();
    check("R7 grant", 32'(lp_grant[0]), 32'h1);
    step();
    check("R7 grant one cycle", 32'(lp_grant[0]), 32'h0);
    rd(v);
    check("R7 flag cleared", 32'(v), 32'h8000);
    repeat (5) step();
    check("R10 single grant", 32'(gcnt0 - g0), 32'h1);
    lp_req[0] = 1'b0;
    step();

    // R6: a write of 1 to the flag bit keeps it pending
    lp_req[1] = 1'b1;
    step();
    wr(16'h8200);
    rd(v);
    check("R6 write one keeps flag", 32'(v), 32'h8200);

    // R11: both pending, acknowledge only mode 0
    g0 = gcnt0;
    g1 = gcnt1;
    lp_req[0] = 1'b1;
    step();
    rd(v);
    check("R11 both pending", 32'(v), 32'h8300);
    wr(16'h8200);
    rd(v);
    check("R11 mode1 still pending", 32'(v), 32'h8200);
    repeat (3) step();
    check("R11 mode0 granted", 32'(gcnt0 - g0), 32'h1);
    check("R11 mode1 not granted", 32'(gcnt1 - g1), 32'h0);

    // R8: withdraw mode 1 while pending
    lp_req[1] = 1'b0;
    step();
    rd(v);
    check("R8 flag dropped", 32'(v), 32'h8000);
    repeat (4) step();
    check("R8 no grant", 32'(gcnt1 - g1), 32'h0);
    lp_req[0] = 1'b0;
    step();

    // R10: re-request after dropping gives a second grant
    g0 = gcnt0;
    lp_req[0] = 1'b1;
    step();
    wr(16'h8000);
    repeat (3) step();
    check("R10 new request new grant", 32'(gcnt0 - g0), 32'h1);
    lp_req[0] = 1'b0;
    step();

    // R9: enable off, immediate grant, no flag
    wr(16'h0000);
    g1 = gcnt1;
    lp_req[1] = 1'b1;
    step();
    check("R9 bypass grant", 32'(lp_grant[1]), 32'h1);
    step();
    check("R9 grant one cycle", 32'(lp_grant[1]), 32'h0);
    rd(v);
    check("R9 no flag", 32'(v), 32'h0);
    repeat (3) step();
    check("R9 single grant", 32'(gcnt1 - g1), 32'h1);
    lp_req[1] = 1'b0;
    step();

    // R1: a reset in mid-handshake clears the pending flag
    wr(16'h8000);
    lp_req[0] = 1'b1;
    step();
    rst = 1'b1;
    step();
    rst = 1'b0;
    lp_req[0] = 1'b0;
    rd(v);
    check("R1 mid reset", 32'(v), 32'h0);

    done = 1'b1;
    summary();
    $finish;
  end
endmodule